// File: doc/BRIEF.md
# Multi-Pixel Sliding Window Line Buffer

This block is a streaming one-dimensional window generator for pixel pipelines that move several adjacent pixels per clock. Each accepted clock brings in a group of `PPC` pixels. The block keeps the most recent earlier groups in a short history. It presents a window of `WIN_LEN` consecutive pixels. The oldest stored pixels sit in the lowest slots, and the group on the input in the same cycle sits in the highest slots. The current group passes straight through without a register, so a window always ends at the pixel being presented now.

The history holds `WIN_LEN/PPC - 1` groups. It advances only on clock edges where the write enable is high, so an upstream stage can stall at will without disturbing the window. A valid flag rises once enough groups have been accepted to fill the history. A chained valid flag marks the cycles in which a fresh window is being produced (valid and write enable both high). Downstream stages can use it as their own write enable, or leave it unconnected. The defaults are 8-bit pixels, two pixels per clock, a four-pixel window and a 30-pixel row. At elaboration the block rejects a window length that is not a whole multiple of `PPC`, a window longer than the row, and a window that holds no earlier group.

Top module: `mp_line_window`

## Requirements
- R1: While the active-low reset is asserted, `valid_o` and `valid_chain_o` are 0 and every history slot of `win_o` (slots 0 to WIN_LEN-PPC-1) reads 0.
- R2: After reset, `valid_o` is 0 while fewer than WIN_LEN/PPC-1 groups have been accepted. It becomes 1 on the clock edge that accepts that many groups and stays 1 until the next reset. With the defaults, it is low for the first accepted group and high from the second onward.
- R3: Pixel k of a group is carried on bits [k*PIX_W +: PIX_W] of `pix_i`, and pixel 0 is the earliest in scan order. Window slot s is carried on bits [s*PIX_W +: PIX_W] of `win_o`. Slots 0 to WIN_LEN-PPC-1 hold the previously accepted groups, oldest group first, with each group's pixels kept in arrival order.
- R4: Slots WIN_LEN-PPC to WIN_LEN-1 of `win_o` equal the pixels on `pix_i` in the same cycle, in arrival order.
- R5: On a clock edge where `wr_en_i` is 0, the input group is not stored: the history slots of `win_o` and `valid_o` keep their values.
- R6: `valid_chain_o` is 1 exactly when `valid_o` and `wr_en_i` are both 1.
- R7: Asserting reset in the middle of a stream clears the history and `valid_o`. Afterwards the fill sequence of R2 starts again from zero groups.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en_i | input | 1 | Accept the present group and advance the history |
| pix_i | input | PPC*PIX_W | Present pixel group, pixel 0 in the low bits |
| win_o | output | WIN_LEN*PIX_W | Window, slot 0 (oldest pixel) in the low bits |
| valid_o | output | 1 | History is full and the window is meaningful |
| valid_chain_o | output | 1 | A fresh valid window is produced this cycle |

## Verification
The bench drives runs of back-to-back writes, then writes that toggle every cycle, then long stalls, then a pseudo-random enable pattern. A design that shifted on stalled edges would show the wrong history after a gap. A design that ordered the pixels of a group or the groups themselves the wrong way round would show swapped slots on every cycle. The bench also looks at the first accepted group after reset: a fill counter that is off by one raises valid a group early or late. A reset in mid-stream checks that the old history and the valid flag do not survive into the new stream. Extreme pixel values (all zeros, all ones, alternating bits) are used so that a missing or crossed bit in a slot shows up.

// File: rtl/lbuf_pkg.sv
package lbuf_pkg;

  // Number of earlier groups kept so that the window can be filled.
  function automatic int groups_held(input int win_len, input int ppc);
    return (win_len / ppc) - 1;
  endfunction

  // Width of a counter that must reach the value n.
  function automatic int count_width(input int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/lbuf_hist.sv
// Group history: NG stages of one group each, oldest in stage 0.
module lbuf_hist #(
  parameter int PIX_W = 8,
  parameter int PPC   = 2,
  parameter int NG    = 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  adv_i,
  input  logic [PPC*PIX_W-1:0]  grp_i,
  output logic [NG*PPC*PIX_W-1:0] hist_o
);
  localparam int GW = PPC * PIX_W;

  logic [GW-1:0] stage_q [NG];
  logic [GW-1:0] stage_d [NG];

  for (genvar g = 0; g < NG; g++) begin : g_stage
    // Each stage takes the next-newer stage; the newest takes the input.
    if (g == NG - 1) begin : g_top
      always_comb begin
        stage_d[g] = stage_q[g];
        if (adv_i) stage_d[g] = grp_i;
      end
    end else begin : g_mid
      always_comb begin
        stage_d[g] = stage_q[g];
        if (adv_i) stage_d[g] = stage_q[g+1];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[g] <= '0;
      else        stage_q[g] <= stage_d[g];
    end

    assign hist_o[g*GW +: GW] = stage_q[g];
  end
endmodule

// File: rtl/lbuf_fill.sv
// Counts accepted groups until the history is full.
module lbuf_fill #(
  parameter int NG = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic adv_i,
  output logic full_o
);
  import lbuf_pkg::*;
  localparam int CW = count_width(NG);
  localparam logic [CW-1:0] LIMIT = CW'(NG);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (adv_i && (cnt_q != LIMIT)) cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign full_o = (cnt_q == LIMIT);
endmodule

// File: rtl/lbuf_assemble.sv
// Joins stored history with the live group and forms the chained flag.
module lbuf_assemble #(
  parameter int PIX_W = 8,
  parameter int PPC   = 2,
  parameter int NG    = 1
) (
  input  logic [NG*PPC*PIX_W-1:0]     hist_i,
  input  logic [PPC*PIX_W-1:0]        grp_i,
  input  logic                        full_i,
  input  logic                        adv_i,
  output logic [(NG+1)*PPC*PIX_W-1:0] win_o,
  output logic                        chain_o
);
  localparam int GW = PPC * PIX_W;
  localparam int HW = NG * GW;

  always_comb begin
    win_o            = '0;
    win_o[HW-1:0]    = hist_i;
    win_o[HW +: GW]  = grp_i;
    chain_o          = full_i & adv_i;
  end
endmodule

// File: rtl/mp_line_window.sv
module mp_line_window #(
  parameter int PIX_W   = 8,
  parameter int PPC     = 2,
  parameter int WIN_LEN = 4,
  parameter int ROW_LEN = 30
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en_i,
  input  logic [PPC*PIX_W-1:0]     pix_i,
  output logic [WIN_LEN*PIX_W-1:0] win_o,
  output logic                     valid_o,
  output logic                     valid_chain_o
);
  import lbuf_pkg::*;
  localparam int NG     = groups_held(WIN_LEN, PPC);
  localparam int HIST_W = NG * PPC * PIX_W;

  if ((WIN_LEN % PPC) != 0) begin : g_bad_mult
    $error("window length must be a multiple of pixels per clock");
  end
  if (WIN_LEN > ROW_LEN || (ROW_LEN % PPC) != 0) begin : g_bad_row
    $error("row length must hold the window and whole groups");
  end
  if (NG < 1) begin : g_bad_depth
    $error("window must span at least two groups");
  end

  logic [HIST_W-1:0] hist;
  logic              full;

  lbuf_hist #(.PIX_W(PIX_W), .PPC(PPC), .NG(NG)) u_hist (
    .clk    (clk),
    .rst_n  (rst_n),
    .adv_i  (wr_en_i),
    .grp_i  (pix_i),
    .hist_o (hist)
  );

  lbuf_fill #(.NG(NG)) u_fill (
    .clk    (clk),
    .rst_n  (rst_n),
    .adv_i  (wr_en_i),
    .full_o (full)
  );

  lbuf_assemble #(.PIX_W(PIX_W), .PPC(PPC), .NG(NG)) u_asm (
    .hist_i  (hist),
    .grp_i   (pix_i),
    .full_i  (full),
    .adv_i   (wr_en_i),
    .win_o   (win_o),
    .chain_o (valid_chain_o)
  );

  assign valid_o = full;
endmodule

// File: rtl/lbuf_chk.sv
module lbuf_chk #(
  parameter int PIX_W   = 8,
  parameter int PPC     = 2,
  parameter int WIN_LEN = 4
) (
  input logic                                  clk,
  input logic                                  rst_n,
  input logic                                  wr_en_i,
  input logic [PPC*PIX_W-1:0]                  pix_i,
  input logic [(WIN_LEN/PPC-1)*PPC*PIX_W-1:0]  hist_i,
  input logic                                  valid_o,
  input logic                                  valid_chain_o
);
  localparam int GW = PPC * PIX_W;
  localparam int NG = WIN_LEN / PPC - 1;

  // R3: an accepted group reappears as the newest history group
  p_shift_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> hist_i[(NG-1)*GW +: GW] == $past(pix_i));

  // R5: a stalled edge leaves history and valid untouched
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_i |=> ($stable(hist_i) && $stable(valid_o)));

  // R2: once valid, stays valid until reset
  p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> valid_o);

  // R2: valid only rises after an accepted group
  p_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid_o) |-> $past(wr_en_i));

  // R6: chained flag never fires without valid and write enable
  p_chain_r6: assert property (@(posedge clk) disable iff (!rst_n)
    valid_chain_o |-> (valid_o && wr_en_i));
endmodule

bind mp_line_window lbuf_chk #(.PIX_W(PIX_W), .PPC(PPC), .WIN_LEN(WIN_LEN)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .wr_en_i       (wr_en_i),
  .pix_i         (pix_i),
  .hist_i        (win_o[HIST_W-1:0]),
  .valid_o       (valid_o),
  .valid_chain_o (valid_chain_o)
);

// File: tb/mp_line_window_bench.sv
module mp_line_window_bench;
  localparam int PW  = 8;
  localparam int PPC = 2;
  localparam int WIN = 4;
  localparam int NG  = WIN / PPC - 1;
  localparam int GW  = PPC * PW;
  localparam int HW  = NG * GW;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic            rst_n, wr_en;
  logic [GW-1:0]   pix;
  logic [WIN*PW-1:0] win;
  logic            valid, chain;

  mp_line_window #(.PIX_W(PW), .PPC(PPC), .WIN_LEN(WIN), .ROW_LEN(30)) u_mp_line_window (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .pix_i(pix),
    .win_o(win), .valid_o(valid), .valid_chain_o(chain)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  logic [GW-1:0] hq[$];
  int  acc;
  bit  prev_en;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_clear();
    hq.delete();
    for (int g = 0; g < NG; g++) hq.push_back('0);
    acc = 0;
    prev_en = 1'b1;
  endtask

  // Drive one cycle, compare before the edge, then update the model.
  task automatic step(input logic en, input logic [GW-1:0] p);
    logic [HW-1:0] exp_h;
    bit exp_v;
    @(negedge clk);
    wr_en = en;
    pix   = p;
    #1;
    for (int g = 0; g < NG; g++) exp_h[g*GW +: GW] = hq[g];
    exp_v = (acc >= NG);
    check(prev_en ? "R3 history" : "R5 history after stall", 64'(win[HW-1:0]), 64'(exp_h));
    check("R4 current group", 64'(win[HW +: GW]), 64'(p));
    check(prev_en ? "R2 valid" : "R5 valid after stall", 64'(valid), 64'(exp_v));
    check("R6 chained valid", 64'(chain), 64'(exp_v && en));
    @(posedge clk);
    if (en) begin
      hq.push_back(p);
      void'(hq.pop_front());
      if (acc < NG) acc++;
    end
    prev_en = en;
  endtask

  task automatic do_reset(input string tag);
    @(negedge clk);
    rst_n = 1'b0;
    wr_en = 1'b0;
    #1;
    check({tag, " valid in reset"}, 64'(valid), 64'd0);
    check({tag, " chain in reset"}, 64'(chain), 64'd0);
    check({tag, " history in reset"}, 64'(win[HW-1:0]), 64'd0);
    @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    model_clear();
  endtask

  initial begin
    logic [15:0] lfsr;
    rst_n = 1'b0;
    wr_en = 1'b0;
    pix   = '0;
    model_clear();
    repeat (2) @(posedge clk);
    do_reset("R1");

    // Back-to-back groups with counting pixels
    for (int i = 0; i < 12; i++)
      step(1'b1, {8'(2*i+1), 8'(2*i)});

    // Toggling write enable with extreme values
    for (int i = 0; i < 16; i++)
      step(i[0] == 1'b0, (i % 4 == 0) ? 16'hFF00 : (i % 4 == 1) ? 16'h00FF :
                         (i % 4 == 2) ? 16'hAA55 : 16'h55AA);

    // Long stall with changing input that must not be stored
    for (int i = 0; i < 6; i++)
      step(1'b0, 16'(16'h1234 * (i + 1)));
    step(1'b1, 16'hFFFF);

    // Pseudo-random enable and data
    lfsr = 16'hACE1;
    for (int i = 0; i < 24; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[3], lfsr ^ 16'h5A5A);
    end

    // Mid-stream reset, then refill from zero
    do_reset("R7");
    step(1'b1, 16'h0201);
    step(1'b0, 16'h0403);
    step(1'b1, 16'h0605);
    step(1'b1, 16'h0807);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule